// File: doc/BRIEF.md
# Frame-Based Transfer List Scheduler

This block chooses, inside each bus frame, which descriptor list a host controller works on next. A frame begins with a start-of-frame strobe and ends with an end-of-frame strobe. The periodic list is served first. Then the control and bulk lists share the rest of the frame under a programmable control-to-bulk service ratio. Descriptor fetch and transfer execution are outside the block. Each list is modelled as a handshake: the block issues a one-cycle grant with a select code, and the list answers with a done pulse when that descriptor has been handled.

The enable bits and the ratio are copied into shadow registers on start-of-frame, so a write made mid-frame has no effect until the next frame. The count of nonempty control descriptors served survives frame boundaries. When the periodic walk reaches an isochronous descriptor while isochronous processing is disabled for the frame, the rest of the periodic list is abandoned and the nonperiodic lists are served.

Top module: `list_sched`

## Requirements
- R1: After reset, sel_o is idle (00), grant_o is 0 and the control service count is zero.
- R2: per_en_i, iso_en_i, ctrl_en_i and ratio_i are sampled only in a cycle with sof_i high. Changes at other times do not alter scheduling until the next start of frame.
- R3: If the sampled periodic enable is set, the frame serves periodic descriptors (select 01) while per_empty_i is low, before any control or bulk grant. If it is clear, no periodic grant is issued in that frame.
- R4: In the periodic phase, if desc_iso_i is high and the sampled isochronous enable is clear, the periodic list is abandoned for the rest of the frame and nonperiodic service begins.
- R5: When both nonperiodic lists are available, a control descriptor (select 10) is granted while the count is less than or equal to ratio_i, and a bulk descriptor (select 11) is granted otherwise. Ratio 00, 01, 10 and 11 therefore give 1, 2, 3 and 4 control descriptors per bulk descriptor.
- R6: The count rises by one only on a control done with ctrl_nonempty_i high. It returns to zero on a bulk done.
- R7: The count is not cleared by start-of-frame or end-of-frame, so the control/bulk pattern continues across frames.
- R8: A control descriptor is granted only if the sampled control enable is set and ctrl_empty_i is low. A bulk descriptor is granted only if bulk_empty_i is low. If one list is unavailable, the other is served regardless of the count. If neither is available, no grant is issued and sel_o stays idle.
- R9: After eof_i, no grant is issued until the next sof_i.
- R10: A grant_o pulse lasts one cycle and appears together with the new select. sel_o holds the granted list until the cycle after done_i, and then returns to idle. The next decision is made one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| per_en_i | input | 1 | Periodic list enable |
| iso_en_i | input | 1 | Isochronous processing enable |
| ctrl_en_i | input | 1 | Control list enable |
| ratio_i | input | 2 | Control-to-bulk service ratio |
| sof_i | input | 1 | Start-of-frame strobe |
| eof_i | input | 1 | End-of-frame strobe |
| desc_iso_i | input | 1 | Current periodic descriptor is isochronous |
| ctrl_nonempty_i | input | 1 | Finished control descriptor carried work (sampled with done_i) |
| per_empty_i | input | 1 | Periodic list exhausted |
| ctrl_empty_i | input | 1 | Control list exhausted |
| bulk_empty_i | input | 1 | Bulk list exhausted |
| done_i | input | 1 | Granted descriptor finished |
| sel_o | output | 2 | List in service: 00 idle, 01 periodic, 10 control, 11 bulk |
| grant_o | output | 1 | One-cycle service grant strobe |

## Verification
A decision is taken at the clock edge from the inputs present in that cycle, and grant_o and sel_o show it right after that edge. A done_i seen at an edge sets sel_o to idle after the same edge, and the next grant can come no earlier than one edge later. A start-of-frame edge only loads the frame phase, so the first grant follows one edge after it, and leaving the periodic phase costs one edge with no grant. The bench drives inputs on the falling edge, advances a behavioural model on the rising edge from the same inputs, and compares both outputs on the following falling edge. It also checks the logged grant order of each frame against the ratio pattern.

// File: rtl/lsch_pkg.sv
package lsch_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE = 2'b00,
    SEL_PER  = 2'b01,
    SEL_CTRL = 2'b10,
    SEL_BULK = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    PH_OFF = 2'b00,
    PH_PER = 2'b01,
    PH_NP  = 2'b10
  } phase_e;
endpackage

// File: rtl/lsch_shadow.sv
module lsch_shadow #(
  parameter int RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sof_i,
  input  logic               per_en_i,
  input  logic               iso_en_i,
  input  logic               ctrl_en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               per_en_o,
  output logic               iso_en_o,
  output logic               ctrl_en_o,
  output logic [RATIO_W-1:0] ratio_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_en_o  <= 1'b0;
      iso_en_o  <= 1'b0;
      ctrl_en_o <= 1'b0;
      ratio_o   <= '0;
    end else if (sof_i) begin
      per_en_o  <= per_en_i;
      iso_en_o  <= iso_en_i;
      ctrl_en_o <= ctrl_en_i;
      ratio_o   <= ratio_i;
    end
  end

  p_shadow_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> ($stable(per_en_o) && $stable(iso_en_o) && $stable(ctrl_en_o) && $stable(ratio_o)));
endmodule

// File: rtl/lsch_ratio_cnt.sv
module lsch_ratio_cnt #(
  parameter int RATIO_W = 2,
  parameter int CNT_W   = RATIO_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_i,
  input  logic               clr_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               ctrl_turn_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= '0;
    else if (clr_i)                       cnt_o <= '0;
    else if (inc_i && (cnt_o != CNT_MAX)) cnt_o <= cnt_o + 1'b1;
  end

  // serve control while count <= ratio code
  assign ctrl_turn_o = (cnt_o <= CNT_W'(ratio_i));

  p_bulk_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_o));
  p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/lsch_pick.sv
module lsch_pick
  import lsch_pkg::*;
(
  input  phase_e phase_i,
  input  logic   per_empty_i,
  input  logic   desc_iso_i,
  input  logic   iso_en_i,
  input  logic   ctrl_en_i,
  input  logic   ctrl_empty_i,
  input  logic   bulk_empty_i,
  input  logic   ctrl_turn_i,
  output logic   leave_per_o,
  output logic   go_o,
  output sel_e   sel_o
);
  logic ctrl_ok, bulk_ok;

  assign ctrl_ok = ctrl_en_i && !ctrl_empty_i;
  assign bulk_ok = !bulk_empty_i;

  always_comb begin
    leave_per_o = 1'b0;
    go_o        = 1'b0;
    sel_o       = SEL_IDLE;
    unique case (phase_i)
      PH_PER: begin
        if (per_empty_i || (desc_iso_i && !iso_en_i)) leave_per_o = 1'b1;
        else begin
          go_o  = 1'b1;
          sel_o = SEL_PER;
        end
      end
      PH_NP: begin
        if (ctrl_ok && (ctrl_turn_i || !bulk_ok)) begin
          go_o  = 1'b1;
          sel_o = SEL_CTRL;
        end else if (bulk_ok) begin
          go_o  = 1'b1;
          sel_o = SEL_BULK;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/list_sched.sv
module list_sched
  import lsch_pkg::*;
#(
  parameter int RATIO_W = 2,
  parameter int CNT_W   = RATIO_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               per_en_i,
  input  logic               iso_en_i,
  input  logic               ctrl_en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               sof_i,
  input  logic               eof_i,
  input  logic               desc_iso_i,
  input  logic               ctrl_nonempty_i,
  input  logic               per_empty_i,
  input  logic               ctrl_empty_i,
  input  logic               bulk_empty_i,
  input  logic               done_i,
  output logic [1:0]         sel_o,
  output logic               grant_o
);
  logic               per_en_s, iso_en_s, ctrl_en_s;
  logic [RATIO_W-1:0] ratio_s;
  logic [CNT_W-1:0]   cnt;
  logic               ctrl_turn, leave_per, pick_go;
  sel_e               pick_sel, sel_q;
  phase_e             phase_q;
  logic               busy_q, grant_q, fin, cnt_inc, cnt_clr;

  lsch_shadow #(.RATIO_W(RATIO_W)) u_shadow (
    .clk_i, .rst_ni, .sof_i, .per_en_i, .iso_en_i, .ctrl_en_i, .ratio_i,
    .per_en_o(per_en_s), .iso_en_o(iso_en_s), .ctrl_en_o(ctrl_en_s), .ratio_o(ratio_s)
  );

  assign fin     = busy_q && done_i;
  assign cnt_inc = fin && (sel_q == SEL_CTRL) && ctrl_nonempty_i;
  assign cnt_clr = fin && (sel_q == SEL_BULK);

  lsch_ratio_cnt #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(cnt_inc), .clr_i(cnt_clr), .ratio_i(ratio_s),
    .cnt_o(cnt), .ctrl_turn_o(ctrl_turn)
  );

  lsch_pick u_pick (
    .phase_i(phase_q), .per_empty_i, .desc_iso_i, .iso_en_i(iso_en_s),
    .ctrl_en_i(ctrl_en_s), .ctrl_empty_i, .bulk_empty_i, .ctrl_turn_i(ctrl_turn),
    .leave_per_o(leave_per), .go_o(pick_go), .sel_o(pick_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      busy_q  <= 1'b0;
      sel_q   <= SEL_IDLE;
      grant_q <= 1'b0;
    end else begin
      grant_q <= 1'b0;
      if (fin) begin
        busy_q <= 1'b0;
        sel_q  <= SEL_IDLE;
      end
      if (sof_i)      phase_q <= per_en_i ? PH_PER : PH_NP;
      else if (eof_i) phase_q <= PH_OFF;
      else if (!busy_q) begin
        if (leave_per) phase_q <= PH_NP;
        else if (pick_go) begin
          grant_q <= 1'b1;
          sel_q   <= pick_sel;
          busy_q  <= 1'b1;
        end
      end
    end
  end

  assign sel_o   = sel_q;
  assign grant_o = grant_q;

  p_grant_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);
  p_sel_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> $stable(sel_o));
  p_off_no_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> ($past(phase_q) != PH_OFF));
  p_grant_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (sel_o != SEL_IDLE));
  p_iso_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PER && desc_iso_i && !iso_en_s && !busy_q && !sof_i && !eof_i)
      |=> !(grant_o && sel_o == SEL_PER));
  p_ctrl_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !ctrl_en_s && !sof_i) |=> !(grant_o && sel_o == SEL_CTRL));
endmodule

// File: tb/list_sched_bench.sv
`timescale 1ns/1ps
module list_sched_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic per_en = 0, iso_en = 0, ctrl_en = 0;
  logic [1:0] ratio = 0;
  logic sof = 0, eof = 0, desc_iso = 0, nonempty = 1;
  logic ctrl_empty = 0, bulk_empty = 0, done = 0;
  logic per_empty;
  logic [1:0] sel;
  logic grant;
  int per_left = 0;
  int lat = 1;
  int checks = 0, fails = 0;
  string cur_req = "R1";
  int log_q[$];

  assign per_empty = (per_left == 0);

  always #5 clk = ~clk;

  list_sched u_list_sched (
    .clk_i(clk), .rst_ni(rst_n), .per_en_i(per_en), .iso_en_i(iso_en),
    .ctrl_en_i(ctrl_en), .ratio_i(ratio), .sof_i(sof), .eof_i(eof),
    .desc_iso_i(desc_iso), .ctrl_nonempty_i(nonempty), .per_empty_i(per_empty),
    .ctrl_empty_i(ctrl_empty), .bulk_empty_i(bulk_empty), .done_i(done),
    .sel_o(sel), .grant_o(grant)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: 0 off, 1 periodic, 2 nonperiodic
  int m_phase = 0, m_cnt = 0, m_sel = 0, m_ratio = 0;
  bit m_busy = 0, m_grant = 0, m_pe = 0, m_ie = 0, m_ce = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_sel = 0; m_busy = 0; m_grant = 0;
      m_pe = 0; m_ie = 0; m_ce = 0; m_ratio = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_grant = 0;
      if (sof) begin
        m_phase = per_en ? 1 : 2;
      end else if (eof) begin
        m_phase = 0;
      end else if (!was_busy) begin
        if (m_phase == 1) begin
          if (per_empty || (desc_iso && !m_ie)) m_phase = 2;
          else begin m_grant = 1; m_sel = 1; m_busy = 1; end
        end else if (m_phase == 2) begin
          bit c_ok, b_ok;
          c_ok = m_ce && !ctrl_empty;
          b_ok = !bulk_empty;
          if (c_ok && (m_cnt <= m_ratio || !b_ok)) begin m_grant = 1; m_sel = 2; m_busy = 1; end
          else if (b_ok) begin m_grant = 1; m_sel = 3; m_busy = 1; end
        end
      end
      if (was_busy && done) begin
        if (m_sel == 2 && nonempty && m_cnt < 7) m_cnt++;
        if (m_sel == 3) m_cnt = 0;
        m_busy = 0; m_sel = 0;
      end
      if (sof) begin
        m_pe = per_en; m_ie = iso_en; m_ce = ctrl_en; m_ratio = int'(ratio);
      end
    end
  end

  // per-cycle comparison and grant log (R10 timing covered here)
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(sel) == m_sel, {cur_req, "/R10 sel"}, int'(sel), m_sel);
      chk(grant == m_grant, {cur_req, "/R10 grant"}, int'(grant), int'(m_grant));
      if (grant) log_q.push_back(int'(sel));
    end
  end

  // list responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && grant) begin
        int kind;
        kind = int'(sel);
        repeat (lat) @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        if (kind == 1 && per_left > 0) per_left--;
      end
    end
  end

  task automatic frame(input int len);
    log_q.delete();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    repeat (len) @(negedge clk);
    eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int count_of(input int v);
    int n = 0;
    foreach (log_q[i]) if (log_q[i] == v) n++;
    return n;
  endfunction

  // checks the nonperiodic pattern after the first bulk grant
  task automatic pattern(input int q[$], input int nctrl, input string req);
    int first = -1;
    foreach (q[i]) if (first < 0 && q[i] == 3) first = i;
    chk(first >= 0, req, first, 0);
    if (first >= 0) begin
      int pos = 0;
      for (int i = first + 1; i < q.size(); i++) begin
        int e = (pos == nctrl) ? 3 : 2;
        chk(q[i] == e, req, q[i], e);
        pos = (pos == nctrl) ? 0 : pos + 1;
      end
    end
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int keep[$];
    int expct[8];
    repeat (3) @(negedge clk);
    chk(sel == 2'b00 && grant == 1'b0, "R1 reset outputs", int'(sel), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sel == 2'b00 && grant == 1'b0, "R1 idle after reset", int'(sel), 0);

    // R3 R5: periodic first, then 2:1
    cur_req = "R3";
    per_en = 1; iso_en = 1; ctrl_en = 1; ratio = 2'b01; per_left = 2;
    frame(40);
    expct = '{1, 1, 2, 2, 3, 2, 2, 3};
    chk(log_q.size() >= 8, "R3 grant count", log_q.size(), 8);
    for (int i = 0; i < 8 && i < log_q.size(); i++)
      chk(log_q[i] == expct[i], "R5 ordering 2:1 with periodic first", log_q[i], expct[i]);

    // R2: mid-frame writes ignored
    cur_req = "R2";
    per_en = 0;
    log_q.delete();
    @(negedge clk); sof = 1; @(negedge clk); sof = 0;
    repeat (10) @(negedge clk);
    ctrl_en = 0; ratio = 2'b11; per_en = 1; per_left = 1;
    repeat (20) @(negedge clk);
    eof = 1; @(negedge clk); eof = 0; repeat (4) @(negedge clk);
    chk(count_of(1) == 0, "R2 periodic not started mid-frame", count_of(1), 0);
    chk(count_of(2) > 0, "R2 control kept mid-frame", count_of(2), 1);
    frame(30);
    chk(log_q.size() > 1 && log_q[0] == 1, "R3 periodic served next frame", log_q[0], 1);
    chk(count_of(2) == 0, "R8 control disabled next frame", count_of(2), 0);
    chk(count_of(3) == log_q.size() - 1, "R8 only bulk after periodic", count_of(3), log_q.size() - 1);

    // R4: isochronous abort
    cur_req = "R4";
    ctrl_en = 1; ratio = 2'b00; iso_en = 0; desc_iso = 1; per_left = 3;
    log_q.delete();
    @(negedge clk); sof = 1; @(negedge clk); sof = 0;
    repeat (8) @(negedge clk);
    iso_en = 1;
    repeat (20) @(negedge clk);
    eof = 1; @(negedge clk); eof = 0; repeat (4) @(negedge clk);
    chk(count_of(1) == 0, "R4 periodic aborted on iso", count_of(1), 0);
    chk(log_q.size() > 0, "R4 nonperiodic served after abort", log_q.size(), 1);
    frame(30);
    chk(log_q.size() >= 3 && log_q[0] == 1 && log_q[1] == 1 && log_q[2] == 1,
        "R4 iso enabled next frame serves periodic", count_of(1), 3);
    desc_iso = 0;

    // R5: ratio 1:1 and 4:1
    cur_req = "R5";
    per_en = 0; per_left = 0; ratio = 2'b00;
    frame(45);
    pattern(log_q, 1, "R5 ratio 00 pattern");
    ratio = 2'b11;
    frame(60);
    pattern(log_q, 4, "R5 ratio 11 pattern");

    // R6: empty control descriptors not counted
    cur_req = "R6";
    ratio = 2'b00; nonempty = 0;
    frame(45);
    chk(count_of(3) <= 1, "R6 no count on empty control", count_of(3), 1);
    chk(count_of(2) >= 5, "R6 control keeps winning", count_of(2), 5);
    nonempty = 1;

    // R7: count persists across frames
    cur_req = "R7";
    ratio = 2'b11;
    keep.delete();
    for (int f = 0; f < 5; f++) begin
      frame(10);
      foreach (log_q[i]) keep.push_back(log_q[i]);
    end
    chk(keep.size() >= 12, "R7 grants across frames", keep.size(), 12);
    pattern(keep, 4, "R7 pattern continues over frames");

    // R8: nothing available
    cur_req = "R8";
    ctrl_en = 0; bulk_empty = 1;
    frame(20);
    chk(log_q.size() == 0, "R8 no grant when both unavailable", log_q.size(), 0);
    ctrl_en = 1; ctrl_empty = 1; bulk_empty = 0;
    frame(20);
    chk(log_q.size() > 0 && count_of(3) == log_q.size(), "R8 empty control yields bulk",
        count_of(3), log_q.size());
    ctrl_empty = 0;

    // R9: quiet between frames
    cur_req = "R9";
    frame(20);
    log_q.delete();
    repeat (25) @(negedge clk);
    chk(log_q.size() == 0, "R9 no grant after eof", log_q.size(), 0);

    // R10: longer latency
    cur_req = "R10";
    lat = 4;
    frame(40);
    chk(log_q.size() > 3, "R10 service with long done latency", log_q.size(), 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule